// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block turns an 18-bit converter code into a stream of 16-bit codes for a coarse converter. The upper sixteen bits of the input pick a coarse level C. The lowest two bits form a fraction. Over a repeating period of four slots, the output spends that fraction of the time at C+1 and the rest at C. A downstream low-pass filter averages the stream, so the time-averaged level gains two bits of resolution over what the coarse converter alone can give.

Slots are timed by a divider on the system clock. The divider ratio comes from two parameters, the system clock frequency and the target slot rate. A one-cycle strobe marks the cycle in which each new slot value appears on the output. A new code enters through a load strobe. It is held back until the next period boundary, so every period is built from a single code.

Top module: `code_dither_interp`

## Requirements
- R1: While `rst` is high, and after it falls until the first slot, `code_out` equals bits [17:2] of the reset code (default 0) and `slot_tick` is low. A reset in mid-run also restarts the slot sequence at slot 0.
- R2: `slot_tick` is high for exactly one cycle every TICK_DIV cycles, where TICK_DIV = CLK_HZ / RATE_HZ. The first pulse comes TICK_DIV cycles after `rst` falls.
- R3: When the active code has a fraction (bits [1:0]) of 0, `code_out` stays at the coarse value (bits [17:2]) in every slot and does not switch.
- R4: Slots are numbered 0 to 3 within each period. Slot 0 is the first slot after reset. Slot n shows C+1 when n is less than the fraction value and shows C otherwise. So fractions 1, 2 and 3 give C+1 in 25%, 50% and 75% of the slots.
- R5: A loaded code becomes active only in the next slot 0. Slots that remain in the current period keep the previous code. A load in the same cycle as the slot-0 strobe waits for the following period.
- R6: When the coarse value is 0xFFFF, `code_out` stays at 0xFFFF for every fraction and never wraps to 0.
- R7: `code_out` changes only in a cycle in which `slot_tick` is high. It is stable at all other times.
- R8: When several loads arrive within one period, the code of the last load is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures `code_in` |
| code_in | input | 18 | Straight-binary code, 0 to 262143 |
| code_out | output | 16 | Coarse code for the converter, registered |
| slot_tick | output | 1 | High in the first cycle of each slot |

## Verification
The new `code_out` value and `slot_tick` both come from the same clock edge. That edge falls TICK_DIV cycles after reset release, and every TICK_DIV cycles after that. The bench therefore waits for a cycle with `slot_tick` high and samples on the falling clock edge inside that cycle. It works out the slot number by counting earlier strobes from reset. A load takes one cycle to reach the pending register. It does not show on the output until the next slot-0 strobe, so the bench applies loads just after a slot-3 strobe, or after a slot-1 strobe for the mid-period case. It then checks four consecutive slots. Between strobes, the bench samples the output in the middle of the slot to confirm it has not moved.

// File: rtl/dither_pkg.sv
`timescale 1ns/1ps
package dither_pkg;

  // Slot divider ratio from clock and slot rate, never below 2.
  function automatic int unsigned div_ratio(input int unsigned clk_hz,
                                            input int unsigned rate_hz);
    int unsigned r;
    r = clk_hz / rate_hz;
    return (r < 2) ? 2 : r;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dit_tick_gen.sv
`timescale 1ns/1ps
module dit_tick_gen #(
  parameter int unsigned DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_now,
  output logic tick_q
);
  localparam int unsigned CNT_W = dither_pkg::cnt_width(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick_now = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt    <= tick_now ? '0 : cnt + 1'b1;
      tick_q <= tick_now;
    end
  end
endmodule

// File: rtl/dit_phase_ctr.sv
`timescale 1ns/1ps
module dit_phase_ctr #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [PH_W-1:0] phase,
  output logic            at_start
);
  assign at_start = (phase == '0);

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/dit_code_hold.sv
`timescale 1ns/1ps
module dit_code_hold #(
  parameter int unsigned       CODE_W     = 18,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code_in,
  input  logic              adopt,
  output logic [CODE_W-1:0] act,
  output logic [CODE_W-1:0] eff
);
  logic [CODE_W-1:0] pend;

  // At a period boundary the pending code is used at once and kept.
  assign eff = adopt ? pend : act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= RESET_CODE;
      act  <= RESET_CODE;
    end else begin
      if (load)  pend <= code_in;
      if (adopt) act  <= pend;
    end
  end
endmodule

// File: rtl/dit_slot_mux.sv
`timescale 1ns/1ps
module dit_slot_mux #(
  parameter int unsigned COARSE_W = 16,
  parameter int unsigned FRAC_W   = 2,
  parameter bit          SATURATE = 1'b1
) (
  input  logic [COARSE_W-1:0] coarse,
  input  logic [FRAC_W-1:0]   frac,
  input  logic [FRAC_W-1:0]   phase,
  output logic [COARSE_W-1:0] level
);
  localparam logic [COARSE_W-1:0] ONE = COARSE_W'(1);

  logic up;
  assign up = (phase < frac);

  generate
    if (SATURATE) begin : g_sat
      logic full;
      assign full  = &coarse;
      assign level = (up && !full) ? coarse + ONE : coarse;
    end else begin : g_wrap
      assign level = up ? coarse + ONE : coarse;
    end
  endgenerate
endmodule

// File: rtl/code_dither_interp.sv
`timescale 1ns/1ps
module code_dither_interp #(
  parameter int unsigned       CLK_HZ     = 50_000_000,
  parameter int unsigned       RATE_HZ    = 10_000,
  parameter int unsigned       CODE_W     = 18,
  parameter int unsigned       FRAC_W     = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [CODE_W-1:0]        code_in,
  output logic [CODE_W-FRAC_W-1:0] code_out,
  output logic                     slot_tick
);
  localparam int unsigned COARSE_W = CODE_W - FRAC_W;
  localparam int unsigned TICK_DIV = dither_pkg::div_ratio(CLK_HZ, RATE_HZ);

  logic                tick_now;
  logic [FRAC_W-1:0]   phase;
  logic                at_start;
  logic [CODE_W-1:0]   act_code;
  logic [CODE_W-1:0]   eff_code;
  logic [COARSE_W-1:0] level;

  dit_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick_now(tick_now), .tick_q(slot_tick)
  );

  dit_phase_ctr #(.PH_W(FRAC_W)) u_phase (
    .clk(clk), .rst(rst), .adv(tick_now), .phase(phase), .at_start(at_start)
  );

  dit_code_hold #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_hold (
    .clk(clk), .rst(rst), .load(load), .code_in(code_in),
    .adopt(tick_now && at_start), .act(act_code), .eff(eff_code)
  );

  dit_slot_mux #(.COARSE_W(COARSE_W), .FRAC_W(FRAC_W), .SATURATE(1'b1)) u_mux (
    .coarse(eff_code[CODE_W-1:FRAC_W]), .frac(eff_code[FRAC_W-1:0]),
    .phase(phase), .level(level)
  );

  always_ff @(posedge clk) begin
    if (rst)           code_out <= RESET_CODE[CODE_W-1:FRAC_W];
    else if (tick_now) code_out <= level;
  end
endmodule

// File: rtl/code_dither_interp_chk.sv
`timescale 1ns/1ps
module code_dither_interp_chk #(
  parameter int unsigned CODE_W = 18,
  parameter int unsigned FRAC_W = 2,
  parameter int unsigned DIV    = 5000
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     slot_tick,
  input logic [CODE_W-FRAC_W-1:0] code_out,
  input logic [CODE_W-1:0]        act_code
);
  localparam int unsigned GAP_W = $clog2(DIV + 1) + 1;
  localparam int unsigned CW    = CODE_W - FRAC_W;

  logic [GAP_W-1:0] gap;
  logic [CW-1:0]    coarse;
  logic [FRAC_W-1:0] frac;

  assign coarse = act_code[CODE_W-1:FRAC_W];
  assign frac   = act_code[FRAC_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) gap <= '0;
    else     gap <= slot_tick ? GAP_W'(1) : gap + 1'b1;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    slot_tick |-> (gap == GAP_W'(DIV)));
  assert_gap_bound_R2: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_W'(DIV));
  assert_hold_between_R7: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |-> $stable(code_out));
  assert_adopt_on_slot_R5: assert property (@(posedge clk) disable iff (rst)
    !slot_tick |-> $stable(act_code));
  assert_adjacent_level_R4: assert property (@(posedge clk) disable iff (rst)
    (code_out == coarse) || (code_out == coarse + CW'(1)));
  assert_flat_frac0_R3: assert property (@(posedge clk) disable iff (rst)
    (frac == '0) |-> (code_out == coarse));
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (&coarse) |-> (&code_out));
endmodule

bind code_dither_interp code_dither_interp_chk #(
  .CODE_W(CODE_W), .FRAC_W(FRAC_W), .DIV(TICK_DIV)
) u_chk (
  .clk(clk), .rst(rst), .slot_tick(slot_tick),
  .code_out(code_out), .act_code(act_code)
);

// File: tb/code_dither_interp_bench.sv
`timescale 1ns/1ps
module code_dither_interp_bench;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [17:0] code_in = '0;
  logic [15:0] code_out;
  logic        slot_tick;

  int vectors = 0;
  int miscompares = 0;
  int n_ticks = 0;
  int phase = 0;

  code_dither_interp #(.CLK_HZ(50_000_000), .RATE_HZ(6_250_000)) u_code_dither_interp (
    .clk(clk), .rst(rst), .load(load), .code_in(code_in),
    .code_out(code_out), .slot_tick(slot_tick)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n_ticks <= 0;
    else if (slot_tick) n_ticks <= n_ticks + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_val(input int code, input int p);
    int c = code >> 2;
    int f = code & 3;
    if (p < f && c != 65535) return c + 1;
    return c;
  endfunction

  task automatic wait_tick();
    do @(negedge clk); while (!slot_tick);
    phase = n_ticks % 4;
  endtask

  task automatic wait_phase(input int p);
    do wait_tick(); while (phase != p);
  endtask

  task automatic load_code(input int code);
    @(negedge clk);
    load = 1'b1; code_in = 18'(code);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic check_period(input int code, input string req);
    for (int p = 0; p < 4; p++) begin
      wait_tick();
      chk({req, " slot phase"}, phase, p);
      chk(req, code_out, exp_val(code, p));
      repeat (4) @(negedge clk);
      chk("R7 mid-slot hold", code_out, exp_val(code, p));
    end
  endtask

  task automatic t_reset();
    int cyc = 0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset output", code_out, 0);
    chk("R1 reset strobe", slot_tick, 0);
    rst = 1'b0;
    do begin @(negedge clk); cyc++; end while (!slot_tick && cyc < 100);
    chk("R2 first strobe delay", cyc, DIV);
    chk("R1 output at first slot", code_out, 0);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!slot_tick && cyc < 100);
    chk("R2 strobe spacing", cyc, DIV);
  endtask

  task automatic t_period(input int code, input string req);
    wait_phase(3);
    load_code(code);
    check_period(code, req);
  endtask

  task automatic t_midload();
    wait_phase(3);
    load_code(4093);
    check_period(4093, "R5 first code");
    wait_phase(1);
    load_code(4095);
    wait_tick(); chk("R5 old code slot 2", code_out, exp_val(4093, 2));
    wait_tick(); chk("R5 old code slot 3", code_out, exp_val(4093, 3));
    check_period(4095, "R5 new code");
  endtask

  task automatic t_lastwins();
    wait_phase(3);
    load_code(8000);
    load_code(8003);
    check_period(8003, "R8 last load");
  endtask

  task automatic t_midreset();
    wait_phase(3);
    load_code(12347);
    check_period(12347, "R4 before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid-run reset output", code_out, 0);
    rst = 1'b0;
    check_period(0, "R1 sequence restart");
  endtask

  initial begin
    #4_000_000;
    miscompares++; vectors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    t_reset();
    t_period(4092, "R3 frac 0");
    t_period(4096, "R3 frac 0 next level");
    t_period(4093, "R4 frac 1");
    t_period(4094, "R4 frac 2");
    t_period(4095, "R4 frac 3");
    t_period(18'h1FFFF, "R4 major carry");
    t_midload();
    t_lastwins();
    t_period(18'h3FFFF, "R6 top frac 3");
    t_period(18'h3FFFD, "R6 top frac 1");
    t_period(18'h3FFFB, "R6 below top");
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule